// File: doc/BRIEF.md
# External Interrupt Line Source Selector

This block sits between the GPIO ports and the external-interrupt edge logic. It receives the level of every pin on nine ports (144 inputs) and drives sixteen line outputs. Line n can only be fed from pin n of some port. A 4-bit selector field chooses which port that is. The line output is a combinational copy of the chosen pin, so the edge detector downstream sees pin transitions with no added latency.

The selector fields are packed four to a 32-bit register. There are four such registers behind a small word-addressed register interface. The same interface holds a 32-bit compensation-cell control register and two configuration registers, one for memory remap and one for peripheral mode. Both of these always read as zero and drop every write. An access anywhere else in the 0x400-byte window reads as zero, drops the write, and pulses an error flag.

Top module: `exti_line_router`

## Requirements
- R1: After synchronous reset every register reads 0, `bus_err` is low, and every line selects port 0, so `line_lvl[n]` equals `pin_lvl[n]`.
- R2: Line n takes its port number p from selector register n/4, bits (n mod 4)*4 to (n mod 4)*4+3. It then drives `pin_lvl[p*16+n]`.
- R3: Levels on pins of ports other than the one selected for a line have no effect on that line.
- R4: A selector field holding a value from 9 to 15 names no port, and its line is driven low.
- R5: The selector registers sit at byte offsets 0x08, 0x0C, 0x10 and 0x14, for lines 0–3, 4–7, 8–11 and 12–15. A write keeps bits 15:0 only, and bits 31:16 always read as 0.
- R6: Writes to the remap register (0x00) and the peripheral-mode register (0x04) are discarded. Both always read 0.
- R7: The compensation register at 0x20 stores all 32 written bits and returns them on read.
- R8: Any byte offset not listed in R5–R7 is unmapped, including unaligned offsets. A read there returns 0, and a write there changes no register.
- R9: `bus_err` is high for exactly the one cycle after an accepted access to an unmapped offset, whether read or write, and low otherwise.
- R10: `bus_rdata` presents the read value in the cycle after the read access. It keeps that value through writes and idle cycles until the next read.
- R11: A selector write takes effect at the clock edge that accepts it. From then on the line follows the current level of the newly selected pin, including pin changes made in the same cycle as the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_acc | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| pin_lvl | input | 144 | Pin levels, index port*16 + pin |
| line_lvl | output | 16 | Interrupt line levels |

## Verification
Two functions can meet in the same cycle: the register path rewriting a selector field, and the routing path forwarding a pin level that is changing at that moment. The bench drives a selector write and a new pin pattern together. It checks that, before the edge, the line shows the new pin level through the old selection. After the edge it must show the new pin level through the new selection. The random phase mixes selector writes with pin changes in the same cycles, and judges every line against a model built from the bench's own copy of the selectors.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int NUM_PORTS  = 9;
    localparam int NUM_LINES  = 16;
    localparam int SEL_W      = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 10;
    localparam int HALF_W     = DATA_W / 2;
    localparam int LINES_PER_REG = HALF_W / SEL_W;
    localparam int NUM_SELREG = NUM_LINES / LINES_PER_REG;
    localparam int SELIDX_W   = $clog2(NUM_SELREG);
    localparam int NUM_PINS   = NUM_PORTS * NUM_LINES;

    localparam logic [ADDR_W-1:0] OFF_REMAP   = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_PMODE   = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_SEL     = 10'h008;
    localparam logic [ADDR_W-1:0] OFF_SEL_END = OFF_SEL + ADDR_W'(4 * NUM_SELREG);
    localparam logic [ADDR_W-1:0] OFF_COMP    = 10'h020;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_REMAP,
        RK_PMODE,
        RK_SEL,
        RK_COMP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e            kind;
        logic [SELIDX_W-1:0]  idx;
    } reg_hit_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        logic [ADDR_W-1:0] rel;
        h.kind = RK_NONE;
        h.idx  = '0;
        rel    = a - OFF_SEL;
        if (a == OFF_REMAP)
            h.kind = RK_REMAP;
        else if (a == OFF_PMODE)
            h.kind = RK_PMODE;
        else if (a == OFF_COMP)
            h.kind = RK_COMP;
        else if (a >= OFF_SEL && a < OFF_SEL_END && a[1:0] == 2'b00) begin
            h.kind = RK_SEL;
            h.idx  = SELIDX_W'(rel >> 2);
        end
        return h;
    endfunction

endpackage

// File: rtl/exti_regfile.sv
module exti_regfile
    import exti_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            acc,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic                            err,
    output logic [NUM_LINES-1:0][SEL_W-1:0] sel
);

    logic [HALF_W-1:0] sel_q [NUM_SELREG];
    logic [DATA_W-1:0] comp_q;
    logic [DATA_W-1:0] rd_mux;
    reg_hit_t          hit;

    assign hit = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SELREG; i++) sel_q[i] <= '0;
            comp_q <= '0;
        end else if (acc && we) begin
            if (hit.kind == RK_SEL)
                sel_q[hit.idx] <= wdata[HALF_W-1:0];
            else if (hit.kind == RK_COMP)
                comp_q <= wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (hit.kind)
            RK_SEL:  rd_mux = {{(DATA_W-HALF_W){1'b0}}, sel_q[hit.idx]};
            RK_COMP: rd_mux = comp_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= acc && (hit.kind == RK_NONE);
            if (acc && !we)
                rdata <= rd_mux;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_field
        assign sel[n] = sel_q[n / LINES_PER_REG][(n % LINES_PER_REG) * SEL_W +: SEL_W];
    end

endmodule

// File: rtl/exti_line_mux.sv
module exti_line_mux
    import exti_pkg::*;
(
    input  logic [NUM_PINS-1:0]             pins,
    input  logic [NUM_LINES-1:0][SEL_W-1:0] sel,
    output logic [NUM_LINES-1:0]            lines
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        always_comb begin
            lines[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel[n] == SEL_W'(p))
                    lines[n] = pins[p * NUM_LINES + n];
            end
        end
    end

endmodule

// File: rtl/exti_line_router.sv
module exti_line_router
    import exti_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_acc,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_err,
    input  logic [NUM_PINS-1:0]   pin_lvl,
    output logic [NUM_LINES-1:0]  line_lvl
);

    logic [NUM_LINES-1:0][SEL_W-1:0] line_sel;

    exti_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .acc   (bus_acc),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .err   (bus_err),
        .sel   (line_sel)
    );

    exti_line_mux u_mux (
        .pins  (pin_lvl),
        .sel   (line_sel),
        .lines (line_lvl)
    );

endmodule

// File: rtl/exti_line_router_chk.sv
module exti_line_router_chk
    import exti_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            bus_acc,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic                            bus_err,
    input logic [NUM_PINS-1:0]             pin_lvl,
    input logic [NUM_LINES-1:0]            line_lvl,
    input logic [NUM_LINES-1:0][SEL_W-1:0] line_sel
);

    reg_kind_e kind;
    assign kind = decode_addr(bus_addr).kind;

    p_err_on_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_acc && kind == RK_NONE) |=> bus_err);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_acc && kind == RK_NONE) |=> !bus_err);

    p_sel_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_acc && !bus_we && kind == RK_SEL) |=> bus_rdata[DATA_W-1:HALF_W] == '0);

    p_ignored_regs_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_acc && !bus_we && (kind == RK_REMAP || kind == RK_PMODE)) |=> bus_rdata == '0);

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_acc && !bus_we && kind == RK_NONE) |=> bus_rdata == '0);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_acc && !bus_we) |=> $stable(bus_rdata));

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
        p_invalid_low_r4: assert property (@(posedge clk) disable iff (rst)
            (line_sel[n] >= SEL_W'(NUM_PORTS)) |-> !line_lvl[n]);

        p_route_r2: assert property (@(posedge clk) disable iff (rst)
            (line_sel[n] < SEL_W'(NUM_PORTS)) |->
                line_lvl[n] == pin_lvl[int'(line_sel[n]) * NUM_LINES + n]);
    end

endmodule

bind exti_line_router exti_line_router_chk u_chk (.*);

// File: tb/exti_line_router_bench.sv
`timescale 1ns/1ps
module exti_line_router_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_acc = 1'b0;
    logic         bus_we = 1'b0;
    logic [9:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [143:0] pin_lvl = '0;
    logic [15:0]  line_lvl;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_sel [4];
    logic [31:0] m_comp;

    always #2 clk = ~clk;

    exti_line_router u_exti_line_router (.*);

    function automatic logic [15:0] exp_lines(input logic [143:0] pins);
        logic [15:0] r;
        for (int n = 0; n < 16; n++) begin
            logic [3:0] p;
            p = m_sel[n / 4][(n % 4) * 4 +: 4];
            r[n] = (p < 4'd9) ? pins[int'(p) * 16 + n] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic is_mapped(input logic [9:0] a);
        return a == 10'h000 || a == 10'h004 || a == 10'h008 || a == 10'h00C ||
               a == 10'h010 || a == 10'h014 || a == 10'h020;
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        case (a)
            10'h008: return {16'h0, m_sel[0]};
            10'h00C: return {16'h0, m_sel[1]};
            10'h010: return {16'h0, m_sel[2]};
            10'h014: return {16'h0, m_sel[3]};
            10'h020: return m_comp;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [9:0] a, input logic [31:0] d);
        case (a)
            10'h008: m_sel[0] = d[15:0];
            10'h00C: m_sel[1] = d[15:0];
            10'h010: m_sel[2] = d[15:0];
            10'h014: m_sel[3] = d[15:0];
            10'h020: m_comp   = d;
            default: ;
        endcase
    endtask

    // called at a negedge; returns at the following negedge
    task automatic do_write(input logic [9:0] a, input logic [31:0] d, output logic e);
        bus_acc = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_acc = 1'b0; bus_we = 1'b0;
        model_write(a, d);
        e = bus_err;
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] d, output logic e);
        bus_acc = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_acc = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic read_all(input string tag);
        logic [31:0] d;
        logic e;
        logic [9:0] map [7] = '{10'h000, 10'h004, 10'h008, 10'h00C, 10'h010, 10'h014, 10'h020};
        for (int i = 0; i < 7; i++) begin
            do_read(map[i], d, e);
            chk(tag, d, exp_read(map[i]));
        end
    endtask

    function automatic logic [143:0] rand_pins();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_sel[i] = '0;
        m_comp = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 err after reset", {31'h0, bus_err}, 32'h0);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        pin_lvl = rand_pins();
        #0.5;
        chk("R1 lines select port 0", {16'h0, line_lvl}, {16'h0, pin_lvl[15:0]});
        read_all("R1 register reset value");

        // R5: selector write masking
        do_write(10'h008, 32'hFFFF_1234, e);
        do_read(10'h008, d, e);
        chk("R5 upper half dropped", d, 32'h0000_1234);

        // R2: line 0 -> port 4, line 1 -> port 3, line 2 -> port 2, line 3 -> port 1
        pin_lvl = '0;
        pin_lvl[4*16 + 0] = 1'b1;
        pin_lvl[3*16 + 1] = 1'b1;
        #0.5;
        chk("R2 field routing", {16'h0, line_lvl}, 32'h0000_0003);
        // line 14 in register 3, bits 11:8 -> port 8
        do_write(10'h014, 32'h0000_0800, e);
        pin_lvl = '0;
        pin_lvl[8*16 + 14] = 1'b1;
        #0.5;
        chk("R2 line 14 from port 8", {31'h0, line_lvl[14]}, 32'h1);

        // R3: all other ports toggled, line 0 stays with port 4 pin 0
        pin_lvl = '1;
        pin_lvl[4*16 + 0] = 1'b0;
        #0.5;
        chk("R3 unselected ports ignored", {31'h0, line_lvl[0]}, 32'h0);
        chk("R3 model match", {16'h0, line_lvl}, {16'h0, exp_lines(pin_lvl)});

        // R4: out-of-range field
        do_write(10'h00C, 32'h0000_F9A8, e);
        pin_lvl = '1;
        #0.5;
        chk("R4 fields 9..15 drive low", {28'h0, line_lvl[7:4]}, 32'h0000_0001);

        // R6: ignored registers
        do_write(10'h000, 32'hFFFF_FFFF, e);
        do_write(10'h004, 32'hA5A5_A5A5, e);
        do_read(10'h000, d, e);
        chk("R6 remap reads zero", d, 32'h0);
        do_read(10'h004, d, e);
        chk("R6 peripheral mode reads zero", d, 32'h0);

        // R7: compensation register
        do_write(10'h020, 32'hDEAD_BEEF, e);
        do_read(10'h020, d, e);
        chk("R7 full word stored", d, 32'hDEAD_BEEF);

        // R8, R9: unmapped write and read
        do_write(10'h018, 32'hFFFF_FFFF, e);
        chk("R9 err after unmapped write", {31'h0, e}, 32'h1);
        @(negedge clk);
        chk("R9 err one cycle only", {31'h0, bus_err}, 32'h0);
        do_write(10'h009, 32'h0000_FFFF, e);
        chk("R9 err after unaligned write", {31'h0, e}, 32'h1);
        do_read(10'h3FC, d, e);
        chk("R8 unmapped read zero", d, 32'h0);
        chk("R9 err after unmapped read", {31'h0, e}, 32'h1);
        do_read(10'h020, d, e);
        chk("R9 no err on mapped read", {31'h0, e}, 32'h0);
        read_all("R8 unmapped writes dropped");

        // R10: rdata holds across writes and idle
        do_read(10'h020, d, e);
        do_write(10'h010, 32'h0000_1111, e);
        repeat (2) @(negedge clk);
        chk("R10 rdata held", bus_rdata, 32'hDEAD_BEEF);

        // R11: selector write and pin change in the same cycle
        pin_lvl = '0;
        pin_lvl[0*16 + 8] = 1'b1;
        #0.5;
        bus_acc = 1'b1; bus_we = 1'b1; bus_addr = 10'h010; bus_wdata = 32'h0000_0006;
        pin_lvl = '0;
        pin_lvl[1*16 + 8] = 1'b1;
        #0.5;
        chk("R11 old selection before edge", {31'h0, line_lvl[8]}, 32'h1);
        @(negedge clk);
        bus_acc = 1'b0; bus_we = 1'b0;
        model_write(10'h010, 32'h0000_0006);
        chk("R11 port 1 pin 8 low after edge", {31'h0, line_lvl[8]}, 32'h0);
        pin_lvl[6*16 + 8] = 1'b1;
        #0.5;
        chk("R11 follows new port", {31'h0, line_lvl[8]}, 32'h1);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [9:0] a;
            op = int'($urandom_range(0, 3));
            pin_lvl = rand_pins();
            case (op)
                0: begin
                    a = 10'h008 + 10'(4 * $urandom_range(0, 3));
                    do_write(a, $urandom, e);
                    chk("R2 random routing", {16'h0, line_lvl}, {16'h0, exp_lines(pin_lvl)});
                end
                1: begin
                    a = 10'($urandom_range(0, 63));
                    do_read(a, d, e);
                    chk("R8 random read", d, exp_read(a));
                    chk("R9 random err", {31'h0, e}, {31'h0, !is_mapped(a)});
                end
                2: begin
                    a = 10'($urandom);
                    do_write(a, $urandom, e);
                    chk("R9 random write err", {31'h0, e}, {31'h0, !is_mapped(a)});
                end
                default: begin
                    @(negedge clk);
                    chk("R3 random pins", {16'h0, line_lvl}, {16'h0, exp_lines(pin_lvl)});
                end
            endcase
        end
        read_all("R5 final register contents");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule